// File: doc/BRIEF.md
# Second-Level Cache Maintenance Register Interface

This block is the memory-mapped control and status slave that sits in front of a shared second-level cache. Software reaches it through a plain register port made of a byte address, a write strobe, write data and combinational read data. It holds the cache enable bits, the ceiling on outstanding memory reads and two event-counter source selectors. It turns command writes into a single request toward the cache array. Through its status word it reports whether the command handler or the data path is busy.

There are two kinds of command, a whole-cache invalidate and a single-page invalidate. Both go through one handler with one busy flag. While that flag is up, any further command write is dropped rather than queued, so software polls the status word before it issues the next command. The handler stays busy until the cache side returns a done strobe. Two event counters each pick one line of an event vector through their selector and count the cycles in which that line is high. They stop at all ones.

Top module: `l2_maint_regs`

## Requirements
- R1: After reset, cache_access_en and read_alloc_en are 0, max_reads is 0x1C, the status word reads 0 (with data_busy_in low), both source selectors and both counter values read 0, and cmd_req is low.
- R2: A write of 0x01 to offset 0x10 while idle raises cmd_req for exactly one cycle, starting the cycle after the write, with cmd_kind 0 and cmd_operand 0. Status bit 0 (command busy) reads 1 from that cycle on.
- R3: A write to offset 0x14 while idle raises the same one-cycle cmd_req with cmd_kind 1 and cmd_operand equal to the written page address, and sets status bit 0.
- R4: While command busy is set, a cycle with cache_done high clears status bit 0 on the following cycle. A cache_done while idle has no effect.
- R5: A write to offset 0x10 or 0x14 while command busy is set produces no cmd_req, leaves cmd_operand and cmd_kind unchanged and keeps status bit 0 set.
- R6: Status bit 1 reads the current level of data_busy_in.
- R7: Offset 0x1C holds two enable bits: bit 0 drives cache_access_en and bit 1 drives read_alloc_en. They read back there, and the upper bits read 0.
- R8: Offset 0x18 is the outstanding-read limit. A write updates max_reads from the next cycle, and the value reads back.
- R9: A write to source selector 0 (offset 0x20) or 1 (offset 0x28) clears the matching value register (offset 0x24 or 0x2C). The value then rises by one for each cycle in which event line s-1 is high, where s is the selector value. A selector of 0, or one above the number of event lines, leaves the value unchanged.
- R10: A counter value that reaches all ones stays there while its event keeps firing.
- R11: Reads of offsets 0x00, 0x04, 0x0C, 0x10 and 0x14, and of any offset at or above 0x30, return 0.
- R12: Writes to the status word (0x08) and to the counter value registers do not change what those registers read back.
- R13: A write to offset 0x10 with any value other than 0x01 issues no command and leaves status bit 0 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| cache_done | input | 1 | Cache array has finished the current command |
| data_busy_in | input | 1 | Cache array is servicing data requests |
| evt_in | input | EVT_NUM | Event strobes that the counters can select |
| cmd_req | output | 1 | One-cycle command request toward the cache array |
| cmd_kind | output | 1 | 0 for whole-cache invalidate, 1 for page invalidate |
| cmd_operand | output | DATA_W | Page address for a page invalidate, 0 otherwise |
| cache_access_en | output | 1 | Cacheable accesses permitted |
| read_alloc_en | output | 1 | Read allocation permitted |
| max_reads | output | MR_W | Limit on outstanding read requests |

## Verification
The hardest case to reach from the ports is a command write that lands while the handler is still busy. The write must be dropped: no request pulse, operand and kind unchanged, busy still set. To reach it, the stimulus holds cache_done low after an accepted whole-cache invalidate and then writes a clear-page command with a distinct address, so a wrongly accepted write would show as both a pulse and a changed operand. Counter saturation is reached by building the bench with a narrow counter width and holding the selected event high for longer than the counter's range. An out-of-range selector and a zero selector are each run against an active event vector.

// File: rtl/l2m_pkg.sv
package l2m_pkg;
   localparam int unsigned OFS_STATUS = 'h08;
   localparam int unsigned OFS_CMD    = 'h10;
   localparam int unsigned OFS_PAGE   = 'h14;
   localparam int unsigned OFS_MAXRD  = 'h18;
   localparam int unsigned OFS_ENABLE = 'h1C;
   localparam int unsigned OFS_SRC0   = 'h20;
   localparam int unsigned OFS_VAL0   = 'h24;
   localparam int unsigned OFS_SRC1   = 'h28;
   localparam int unsigned OFS_VAL1   = 'h2C;
   localparam int unsigned WINDOW     = 'h30;

   localparam int unsigned CLR_ALL_CODE = 'h01;

   localparam int unsigned ST_CMD_BUSY  = 0;
   localparam int unsigned ST_DATA_BUSY = 1;
   localparam int unsigned EN_ACCESS    = 0;
   localparam int unsigned EN_RALLOC    = 1;

   typedef enum logic {
      KIND_ALL  = 1'b0,
      KIND_PAGE = 1'b1
   } cmd_kind_e;
endpackage

// File: rtl/l2m_cmd_ctrl.sv
module l2m_cmd_ctrl
   import l2m_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_all,
   input  logic              wr_page,
   input  logic [DATA_W-1:0] page_addr,
   input  logic              done,
   output logic              req,
   output cmd_kind_e         kind,
   output logic [DATA_W-1:0] operand,
   output logic              busy
);
   logic accept;
   assign accept = !busy && (wr_all || wr_page);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req     <= 1'b0;
         busy    <= 1'b0;
         kind    <= KIND_ALL;
         operand <= '0;
      end else begin
         req <= accept;
         if (accept) begin
            busy    <= 1'b1;
            kind    <= wr_page ? KIND_PAGE : KIND_ALL;
            operand <= wr_page ? page_addr : '0;
         end else if (busy && done) begin
            busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/l2m_evt_counter.sv
module l2m_evt_counter #(
   parameter int SRC_W   = 8,
   parameter int EVT_NUM = 8,
   parameter int CNT_W   = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               src_wr,
   input  logic [SRC_W-1:0]   src_wdata,
   input  logic [EVT_NUM-1:0] evt,
   output logic [SRC_W-1:0]   src,
   output logic [CNT_W-1:0]   val
);
   logic hit;

   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < EVT_NUM; i++) begin
         if (src == SRC_W'(i + 1)) hit = evt[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src <= '0;
         val <= '0;
      end else if (src_wr) begin
         src <= src_wdata;
         val <= '0;
      end else if (hit && (val != '1)) begin
         val <= val + 1'b1;
      end
   end
endmodule

// File: rtl/l2_maint_regs.sv
module l2_maint_regs
   import l2m_pkg::*;
#(
   parameter int          ADDR_W   = 6,
   parameter int          DATA_W   = 32,
   parameter int          MR_W     = 8,
   parameter int unsigned MR_RESET = 'h1C,
   parameter int          SRC_W    = 8,
   parameter int          EVT_NUM  = 8,
   parameter int          CNT_W    = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               cache_done,
   input  logic               data_busy_in,
   input  logic [EVT_NUM-1:0] evt_in,
   output logic               cmd_req,
   output logic               cmd_kind,
   output logic [DATA_W-1:0]  cmd_operand,
   output logic               cache_access_en,
   output logic               read_alloc_en,
   output logic [MR_W-1:0]    max_reads
);
   localparam int NUM_CNT = 2;

   if (ADDR_W < 6) begin : g_bad_addr
      $error("ADDR_W too small for the register window");
   end
   if (CNT_W > DATA_W || SRC_W > DATA_W || MR_W > DATA_W) begin : g_bad_width
      $error("register field wider than the data bus");
   end
   if (EVT_NUM >= (1 << SRC_W)) begin : g_bad_evt
      $error("selector too narrow for the event count");
   end

   function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic                        cmd_busy;
   cmd_kind_e                   kind_q;
   logic [1:0]                  en_q;
   logic [MR_W-1:0]             mr_q;
   logic [NUM_CNT-1:0]          src_wr;
   logic [NUM_CNT-1:0][SRC_W-1:0] cnt_src;
   logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;

   l2m_cmd_ctrl #(.DATA_W(DATA_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_all    (bus_wr && at(bus_addr, OFS_CMD) && (bus_wdata == DATA_W'(CLR_ALL_CODE))),
      .wr_page   (bus_wr && at(bus_addr, OFS_PAGE)),
      .page_addr (bus_wdata),
      .done      (cache_done),
      .req       (cmd_req),
      .kind      (kind_q),
      .operand   (cmd_operand),
      .busy      (cmd_busy)
   );
   assign cmd_kind = kind_q;

   assign src_wr[0] = bus_wr && at(bus_addr, OFS_SRC0);
   assign src_wr[1] = bus_wr && at(bus_addr, OFS_SRC1);

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      l2m_evt_counter #(.SRC_W(SRC_W), .EVT_NUM(EVT_NUM), .CNT_W(CNT_W)) u_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .src_wr    (src_wr[k]),
         .src_wdata (bus_wdata[SRC_W-1:0]),
         .evt       (evt_in),
         .src       (cnt_src[k]),
         .val       (cnt_val[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
         mr_q <= MR_W'(MR_RESET);
      end else if (bus_wr) begin
         if (at(bus_addr, OFS_ENABLE)) en_q <= bus_wdata[1:0];
         if (at(bus_addr, OFS_MAXRD))  mr_q <= bus_wdata[MR_W-1:0];
      end
   end

   assign cache_access_en = en_q[EN_ACCESS];
   assign read_alloc_en   = en_q[EN_RALLOC];
   assign max_reads       = mr_q;

   always_comb begin
      bus_rdata = '0;
      if (at(bus_addr, OFS_STATUS)) begin
         bus_rdata[ST_CMD_BUSY]  = cmd_busy;
         bus_rdata[ST_DATA_BUSY] = data_busy_in;
      end
      if (at(bus_addr, OFS_MAXRD))  bus_rdata = DATA_W'(mr_q);
      if (at(bus_addr, OFS_ENABLE)) bus_rdata = DATA_W'(en_q);
      if (at(bus_addr, OFS_SRC0))   bus_rdata = DATA_W'(cnt_src[0]);
      if (at(bus_addr, OFS_VAL0))   bus_rdata = DATA_W'(cnt_val[0]);
      if (at(bus_addr, OFS_SRC1))   bus_rdata = DATA_W'(cnt_src[1]);
      if (at(bus_addr, OFS_VAL1))   bus_rdata = DATA_W'(cnt_val[1]);
   end
endmodule

// File: rtl/l2m_checker.sv
module l2m_checker
   import l2m_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              cache_done,
   input logic              cmd_req,
   input logic              cmd_busy,
   input logic [DATA_W-1:0] cmd_operand,
   input logic [CNT_W-1:0]  val0,
   input logic [CNT_W-1:0]  val1
);
   logic src0_wr, src1_wr;
   assign src0_wr = bus_wr && (bus_addr == ADDR_W'(OFS_SRC0));
   assign src1_wr = bus_wr && (bus_addr == ADDR_W'(OFS_SRC1));

   // R2: a request is always accompanied by the busy flag
   a_r2_req_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> cmd_busy);

   // R2: the request never lasts two cycles
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |=> !cmd_req);

   // R5: while busy without done, nothing new is accepted
   a_r5_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_busy && !cache_done) |=> (cmd_busy && !cmd_req && $stable(cmd_operand)));

   // R4: done while busy returns the handler to idle
   a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_busy && cache_done) |=> !cmd_busy);

   // R10: a full counter does not wrap
   a_r10_sat0: assert property (@(posedge clk) disable iff (!rst_n)
      ((val0 == '1) && !src0_wr) |=> (val0 == '1));
   a_r10_sat1: assert property (@(posedge clk) disable iff (!rst_n)
      ((val1 == '1) && !src1_wr) |=> (val1 == '1));
endmodule

bind l2_maint_regs l2m_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr      (bus_wr),
   .bus_addr    (bus_addr),
   .cache_done  (cache_done),
   .cmd_req     (cmd_req),
   .cmd_busy    (cmd_busy),
   .cmd_operand (cmd_operand),
   .val0        (cnt_val[0]),
   .val1        (cnt_val[1])
);

// File: tb/l2_maint_regs_tb.sv
module l2_maint_regs_tb;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W = 6;
   localparam int DATA_W = 32;
   localparam int MR_W   = 8;
   localparam int EVT_N  = 8;
   localparam int CNT_W  = 6;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [ADDR_W-1:0]  bus_addr = '0;
   logic               bus_wr = 1'b0;
   logic [DATA_W-1:0]  bus_wdata = '0;
   logic [DATA_W-1:0]  bus_rdata;
   logic               cache_done = 1'b0;
   logic               data_busy_in = 1'b0;
   logic [EVT_N-1:0]   evt_in = '0;
   logic               cmd_req, cmd_kind, cache_access_en, read_alloc_en;
   logic [DATA_W-1:0]  cmd_operand;
   logic [MR_W-1:0]    max_reads;

   always #(CLK_PERIOD / 2) clk = ~clk;

   l2_maint_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MR_W(MR_W),
                   .EVT_NUM(EVT_N), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cache_done(cache_done),
      .data_busy_in(data_busy_in), .evt_in(evt_in), .cmd_req(cmd_req),
      .cmd_kind(cmd_kind), .cmd_operand(cmd_operand),
      .cache_access_en(cache_access_en), .read_alloc_en(read_alloc_en),
      .max_reads(max_reads)
   );

   typedef struct {
      logic [DATA_W-1:0] exp;
      string             tag;
   } item_t;

   item_t sb_q[$];
   event  rd_ev;
   int    n_chk = 0;
   int    n_bad = 0;
   int    cyc   = 0;
   bit    done_run = 1'b0;

   task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data and compares against the bus
   initial begin
      forever begin
         @(rd_ev);
         #1;
         while (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic wr(input int unsigned a, input logic [DATA_W-1:0] d);
      @(negedge clk);
      bus_addr  = ADDR_W'(a);
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic rd(input int unsigned a, input logic [DATA_W-1:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      bus_addr = ADDR_W'(a);
      it.exp = exp;
      it.tag = tag;
      sb_q.push_back(it);
      #1;
      -> rd_ev;
      #2;
   endtask

   task automatic evts(input int n, input logic [EVT_N-1:0] pat);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         evt_in = pat;
      end
      @(negedge clk);
      evt_in = '0;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      cache_done = 1'b1;
      @(negedge clk);
      cache_done = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done_run) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 access_en", DATA_W'(cache_access_en), 0);
      check("R1 ralloc_en", DATA_W'(read_alloc_en), 0);
      check("R1 max_reads", DATA_W'(max_reads), 'h1C);
      check("R1 cmd_req", DATA_W'(cmd_req), 0);
      rd('h08, 0, "R1 status");
      rd('h18, 'h1C, "R1 maxrd read");
      rd('h20, 0, "R1 src0");
      rd('h24, 0, "R1 val0");
      rd('h28, 0, "R1 src1");
      rd('h2C, 0, "R1 val1");

      // R11 unused and command offsets read zero
      wr('h14, 'h0);   // accepted page command with address 0, clear it
      done_pulse();
      rd('h00, 0, "R11 0x00");
      rd('h04, 0, "R11 0x04");
      rd('h0C, 0, "R11 0x0C");
      rd('h10, 0, "R11 0x10");
      rd('h14, 0, "R11 0x14");
      rd('h30, 0, "R11 0x30");
      rd('h3C, 0, "R11 0x3C");

      // R6 data busy passthrough
      data_busy_in = 1'b1;
      rd('h08, 'h2, "R6 data busy");
      data_busy_in = 1'b0;
      rd('h08, 'h0, "R6 data idle");

      // R13 wrong command code
      wr('h10, 'h2);
      check("R13 no req", DATA_W'(cmd_req), 0);
      rd('h08, 0, "R13 still idle");

      // R2 clear-all
      wr('h10, 'h1);
      check("R2 req", DATA_W'(cmd_req), 1);
      check("R2 kind", DATA_W'(cmd_kind), 0);
      check("R2 operand", cmd_operand, 0);
      rd('h08, 'h1, "R2 busy");
      check("R2 pulse ends", DATA_W'(cmd_req), 0);

      // R5 page write while busy dropped
      wr('h14, 'hDEAD0);
      check("R5 no req", DATA_W'(cmd_req), 0);
      check("R5 operand kept", cmd_operand, 0);
      check("R5 kind kept", DATA_W'(cmd_kind), 0);
      wr('h10, 'h1);
      check("R5 no req all", DATA_W'(cmd_req), 0);
      rd('h08, 'h1, "R5 still busy");

      // R4 done clears busy
      done_pulse();
      rd('h08, 'h0, "R4 idle after done");
      done_pulse();
      rd('h08, 'h0, "R4 done while idle");

      // R3 clear-page
      wr('h14, 'hABC00);
      check("R3 req", DATA_W'(cmd_req), 1);
      check("R3 kind", DATA_W'(cmd_kind), 1);
      check("R3 operand", cmd_operand, 'hABC00);
      rd('h08, 'h1, "R3 busy");
      done_pulse();
      rd('h08, 'h0, "R3 idle");

      // R7 enable bits
      wr('h1C, 'hFFFF_FFFD);
      check("R7 access", DATA_W'(cache_access_en), 1);
      check("R7 ralloc", DATA_W'(read_alloc_en), 0);
      rd('h1C, 'h1, "R7 readback");
      wr('h1C, 'h2);
      check("R7 access off", DATA_W'(cache_access_en), 0);
      check("R7 ralloc on", DATA_W'(read_alloc_en), 1);

      // R8 max reads
      wr('h18, 'h07);
      check("R8 output", DATA_W'(max_reads), 'h07);
      rd('h18, 'h07, "R8 readback");

      // R12 read-only registers
      wr('h08, 'h3);
      rd('h08, 'h0, "R12 status");

      // R9 counting on event line 2 (selector 3)
      wr('h20, 'h3);
      evts(5, 8'b0000_0100);
      evts(4, 8'b1111_1011);
      rd('h24, 5, "R9 val0 count");
      rd('h20, 3, "R9 src0 readback");
      wr('h24, 'h1F);
      rd('h24, 5, "R12 val0 write ignored");
      wr('h20, 'h3);
      rd('h24, 0, "R9 src write clears");
      wr('h20, 'h0);
      evts(6, 8'hFF);
      rd('h24, 0, "R9 zero selector");
      wr('h28, 'h9);
      evts(6, 8'hFF);
      rd('h2C, 0, "R9 out-of-range selector");
      wr('h28, 'h8);
      evts(3, 8'h80);
      rd('h2C, 3, "R9 top event line");

      // R10 saturation
      wr('h28, 'h1);
      evts(80, 8'h01);
      rd('h2C, 'h3F, "R10 saturated");
      wr('h2C, 'h0);
      rd('h2C, 'h3F, "R12 val1 write ignored");

      done_run = 1'b1;
      #20;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule